// File: doc/BRIEF.md
# SPI-to-Infrared Bridge Command Decoder

This block is a slave on a cartridge's auxiliary SPI bus. It shares that bus between a save memory and an infrared link that runs as a UART. Each time chip select is asserted, the first byte the host shifts in is taken as a command.

The command picks one of four behaviours for the rest of that chip-select period:
- forward the transaction to the save memory;
- return buffered infrared receive data behind a one-byte length prefix;
- stream host bytes out to the infrared transmitter;
- answer a one-byte status query.

The SPI pins are oversampled in the system clock domain through synchronizers. Receive bytes from the UART collect in a buffer of up to 255 entries. Bytes for transmission wait in a FIFO that the UART transmitter drains at a fixed 8N1 baud rate. The baud divisor is derived from the `CLK_HZ` and `BAUD` parameters.

Top module: `irspi_bridge`

## Requirements
- R1: The SPI side works in mode 0 with MSB first. Data is sampled on SCK rising edges and the next bit is driven after falling edges. While the command byte is shifted in, MISO returns 0xFF, and MISO is 1 while chip select is high.
- R2: Releasing chip select always returns the decoder to command state, so the first byte of the next selection is decoded as a command.
- R3: Command 0x00 opens passthrough for the rest of the selection. mem_cs_n goes low, SCK and MOSI are forwarded to the memory, and MISO follows mem_miso. mem_cs_n is high whenever chip select is high or no passthrough is open.
- R4: Command 0x01 snapshots the receive buffer level N (at most 255) and shifts it out in the next byte. The next N bytes return the buffered infrared bytes oldest first, and each one is removed from the buffer. Any further bytes return 0x00.
- R5: Command 0x01 with an empty receive buffer returns a count of 0x00. The following selection is decoded normally.
- R6: Bytes the host writes during a 0x01 read are ignored: they are neither transmitted nor able to change the reply.
- R7: After command 0x02, every following byte of the selection goes into the transmit FIFO and is sent over the UART in order. The stream ends when chip select is released.
- R8: Command 0x08 returns one status byte. The first 0x08 after reset or after any other command returns 0x00, and every further consecutive 0x08 returns 0xAA.
- R9: If the receive buffer holds data or a UART frame is being received when 0x08 is decoded, the status byte is 0xAA.
- R10: Any other command byte returns 0xFF for the rest of the selection and has no other effect: nothing is transmitted and the status sequence restarts.
- R11: UART frames are 8N1, LSB first, each bit CLK_HZ/BAUD clocks long, and the line idles high. A received frame with a valid start and stop bit lands in the receive buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_sck | input | 1 | Host serial clock |
| spi_mosi | input | 1 | Host to slave data |
| spi_miso | output | 1 | Slave to host data |
| mem_cs_n | output | 1 | Save memory chip select, active low |
| mem_sck | output | 1 | Forwarded serial clock to save memory |
| mem_mosi | output | 1 | Forwarded data to save memory |
| mem_miso | input | 1 | Data from save memory |
| uart_rx | input | 1 | Infrared receive line |
| uart_tx | output | 1 | Infrared transmit line |

## Verification
The SPI pins pass through two synchronizer stages and one register. A reply byte is therefore in the shift register about three clocks after the SCK falling edge that closes a byte. The bench holds each SCK phase for eight clocks and samples MISO just before each rising edge, well after that point. A UART byte reaches the receive buffer a few clocks after its stop-bit midpoint, so the bench waits twenty clocks after each full frame before it reads. Transmit frames start within a few clocks of a push and take ten bit times each. A free-running monitor decodes them at mid-bit, and its count is checked only after a margin of several frames has passed.

// File: rtl/irspi_pkg.sv
package irspi_pkg;
   typedef enum logic [2:0] {
      ST_CMD,
      ST_PASS,
      ST_READ,
      ST_SEND,
      ST_DONE
   } dec_state_t;

   localparam logic [7:0] CMD_ESCAPE = 8'h00;
   localparam logic [7:0] CMD_IRREAD = 8'h01;
   localparam logic [7:0] CMD_IRSEND = 8'h02;
   localparam logic [7:0] CMD_STATUS = 8'h08;
   localparam logic [7:0] STAT_QUIET = 8'h00;
   localparam logic [7:0] STAT_BUSY  = 8'hAA;
   localparam logic [7:0] FILL_BYTE  = 8'hFF;
   localparam logic [7:0] PAD_BYTE   = 8'h00;
endpackage

// File: rtl/irspi_fifo.sv
module irspi_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [WIDTH-1:0]               wdata,
   input  logic                           pop,
   output logic [WIDTH-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0]     count
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH+1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("irspi_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic             push_ok, pop_ok;

   assign push_ok = push && (count != CW'(DEPTH));
   assign pop_ok  = pop && (count != '0);
   assign rdata   = mem[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign wr_nx = wr_ptr + 1'b1;
      assign rd_nx = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nx = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nx = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nx;
         if (pop_ok)  rd_ptr <= rd_nx;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end
endmodule

// File: rtl/irspi_uart_rx.sv
module irspi_uart_rx #(
   parameter int DIV = 1085
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data,
   output logic       busy
);
   localparam int CNTW = $clog2(DIV+1);

   logic [1:0]      rxd_p;
   logic            rxd_s;
   logic [CNTW-1:0] cnt;
   logic [3:0]      bitn;

   assign rxd_s = rxd_p[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxd_p <= 2'b11;
         cnt   <= '0;
         bitn  <= '0;
         busy  <= 1'b0;
         valid <= 1'b0;
         data  <= '0;
      end else begin
         rxd_p <= {rxd_p[0], rxd};
         valid <= 1'b0;
         if (!busy) begin
            if (!rxd_s) begin
               busy <= 1'b1;
               cnt  <= CNTW'(DIV/2);
               bitn <= '0;
            end
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            cnt  <= CNTW'(DIV-1);
            bitn <= bitn + 1'b1;
            if (bitn == 4'd0) begin
               if (rxd_s) busy <= 1'b0;
            end else if (bitn <= 4'd8) begin
               data <= {rxd_s, data[7:1]};
            end else begin
               busy  <= 1'b0;
               valid <= rxd_s;
            end
         end
      end
   end
endmodule

// File: rtl/irspi_uart_tx.sv
module irspi_uart_tx #(
   parameter int DIV = 1085
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] data,
   output logic       busy,
   output logic       txd
);
   localparam int CNTW = $clog2(DIV+1);

   logic [9:0]      sh;
   logic [3:0]      left;
   logic [CNTW-1:0] cnt;

   assign txd = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (!busy) begin
         if (load) begin
            sh   <= {1'b1, data, 1'b0};
            left <= 4'd10;
            cnt  <= CNTW'(DIV-1);
            busy <= 1'b1;
         end
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else begin
         sh   <= {1'b1, sh[9:1]};
         cnt  <= CNTW'(DIV-1);
         left <= left - 1'b1;
         if (left == 4'd1) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/irspi_bridge.sv
module irspi_bridge #(
   parameter int CLK_HZ      = 125_000_000,
   parameter int BAUD        = 115_200,
   parameter int RX_DEPTH    = 255,
   parameter int TX_DEPTH    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic mem_cs_n,
   output logic mem_sck,
   output logic mem_mosi,
   input  logic mem_miso,
   input  logic uart_rx,
   output logic uart_tx
);
   import irspi_pkg::*;

   localparam int DIV   = CLK_HZ / BAUD;
   localparam int RX_CW = $clog2(RX_DEPTH+1);
   localparam int TX_CW = $clog2(TX_DEPTH+1);

   if (RX_DEPTH < 2 || RX_DEPTH > 255) begin : g_bad_rx
      $error("irspi_bridge: RX_DEPTH must fit the one-byte length prefix");
   end
   if (TX_DEPTH < 2) begin : g_bad_tx
      $error("irspi_bridge: TX_DEPTH must be at least 2");
   end
   if (DIV < 4) begin : g_bad_div
      $error("irspi_bridge: CLK_HZ/BAUD must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irspi_bridge: SYNC_STAGES must be at least 2");
   end

   // pin synchronizers
   logic [SYNC_STAGES-1:0] sck_p, cs_p, mosi_p;
   logic sck_s, cs_s, mosi_s, sck_last;
   assign sck_s  = sck_p[SYNC_STAGES-1];
   assign cs_s   = cs_p[SYNC_STAGES-1];
   assign mosi_s = mosi_p[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p    <= '0;
         cs_p     <= '1;
         mosi_p   <= '0;
         sck_last <= 1'b0;
      end else begin
         sck_p    <= {sck_p[SYNC_STAGES-2:0], spi_sck};
         cs_p     <= {cs_p[SYNC_STAGES-2:0], spi_cs_n};
         mosi_p   <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
         sck_last <= sck_s;
      end
   end

   logic rise, fall;
   assign rise = sck_s && !sck_last && !cs_s;
   assign fall = !sck_s && sck_last && !cs_s;

   // command decoder state
   dec_state_t state;
   logic [2:0] bit_cnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh, nxt_byte, remain, rbyte;
   logic       stat_seen, byte_done;

   // buffers and UART
   logic [RX_CW-1:0] rx_count;
   logic [TX_CW-1:0] tx_count;
   logic [7:0]       rx_head, tx_head, rx_data, rx_level8;
   logic             rx_valid, rx_busy, rd_pop, tx_push, tx_load, tx_busy, ir_active;

   assign rbyte     = {rx_sh, mosi_s};
   assign byte_done = rise && (bit_cnt == 3'd7);
   assign rd_pop    = byte_done && (state == ST_READ) && (remain != 8'd0);
   assign tx_push   = byte_done && (state == ST_SEND);
   assign tx_load   = !tx_busy && (tx_count != '0);
   assign rx_level8 = 8'(rx_count);
   assign ir_active = (rx_count != '0) || rx_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CMD;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= FILL_BYTE;
         nxt_byte  <= FILL_BYTE;
         remain    <= '0;
         stat_seen <= 1'b0;
      end else if (cs_s) begin
         state   <= ST_CMD;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= FILL_BYTE;
      end else begin
         if (rise) begin
            rx_sh   <= rbyte[6:0];
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (byte_done) begin
            nxt_byte <= FILL_BYTE;
            unique case (state)
               ST_CMD: begin
                  stat_seen <= 1'b0;
                  unique case (rbyte)
                     CMD_ESCAPE: state <= ST_PASS;
                     CMD_IRREAD: begin
                        state    <= ST_READ;
                        remain   <= rx_level8;
                        nxt_byte <= rx_level8;
                     end
                     CMD_IRSEND: state <= ST_SEND;
                     CMD_STATUS: begin
                        state     <= ST_DONE;
                        stat_seen <= 1'b1;
                        nxt_byte  <= (stat_seen || ir_active) ? STAT_BUSY : STAT_QUIET;
                     end
                     default: state <= ST_DONE;
                  endcase
               end
               ST_READ: begin
                  if (remain != 8'd0) begin
                     nxt_byte <= rx_head;
                     remain   <= remain - 1'b1;
                  end else begin
                     nxt_byte <= PAD_BYTE;
                  end
               end
               default: ;
            endcase
         end
         if (fall) begin
            if (bit_cnt == 3'd0) tx_sh <= nxt_byte;
            else                 tx_sh <= {tx_sh[6:0], 1'b1};
         end
      end
   end

   logic pass;
   assign pass     = (state == ST_PASS);
   assign mem_cs_n = spi_cs_n || !pass;
   assign mem_sck  = pass && spi_sck;
   assign mem_mosi = pass && spi_mosi;
   assign spi_miso = pass ? mem_miso : tx_sh[7];

   irspi_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_buf (
      .clk(clk), .rst_n(rst_n), .push(rx_valid), .wdata(rx_data),
      .pop(rd_pop), .rdata(rx_head), .count(rx_count)
   );

   irspi_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_tx_buf (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(rbyte),
      .pop(tx_load), .rdata(tx_head), .count(tx_count)
   );

   irspi_uart_rx #(.DIV(DIV)) u_urx (
      .clk(clk), .rst_n(rst_n), .rxd(uart_rx),
      .valid(rx_valid), .data(rx_data), .busy(rx_busy)
   );

   irspi_uart_tx #(.DIV(DIV)) u_utx (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .data(tx_head),
      .busy(tx_busy), .txd(uart_tx)
   );
endmodule

// File: rtl/irspi_bridge_chk.sv
module irspi_bridge_chk #(
   parameter int DIV = 1085
) (
   input logic clk,
   input logic rst_n,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi,
   input logic spi_miso,
   input logic mem_cs_n,
   input logic mem_sck,
   input logic mem_mosi,
   input logic mem_miso,
   input logic uart_tx
);
   int unsigned low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        low_run <= 0;
      else if (!uart_tx) low_run <= low_run + 1;
      else               low_run <= 0;
   end

   AST_MISO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4)) |-> spi_miso); // R1

   AST_MEM_CS_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> mem_cs_n); // R3

   AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> ((spi_miso == mem_miso) && (mem_sck == spi_sck) && (mem_mosi == spi_mosi))); // R3

   AST_MEM_OPEN_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs_n) |-> !spi_cs_n); // R3

   AST_TX_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= 9 * DIV); // R11
endmodule

bind irspi_bridge irspi_bridge_chk #(.DIV(DIV)) u_irspi_chk (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
   .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_cs_n(mem_cs_n),
   .mem_sck(mem_sck), .mem_mosi(mem_mosi), .mem_miso(mem_miso),
   .uart_tx(uart_tx)
);

// File: tb/test_irspi_bridge.sv
module test_irspi_bridge;
   localparam int CLK_HZ = 921_600;   // scaled so CLK_HZ/BAUD = 8
   localparam int DIV    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, mem_miso = 1'b0, uart_rx = 1'b1;
   logic spi_miso, mem_cs_n, mem_sck, mem_mosi, uart_tx;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   irspi_bridge #(.CLK_HZ(CLK_HZ), .BAUD(115_200)) i_irspi_bridge (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_cs_n(mem_cs_n),
      .mem_sck(mem_sck), .mem_mosi(mem_mosi), .mem_miso(mem_miso),
      .uart_rx(uart_rx), .uart_tx(uart_tx)
   );

   // UART transmit monitor
   logic [7:0] txcap [8];
   int txn = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !uart_tx) begin
            logic [7:0] b;
            repeat (DIV/2) @(negedge clk);
            for (int k = 0; k < 8; k++) begin
               repeat (DIV) @(negedge clk);
               b[k] = uart_tx;
            end
            repeat (DIV) @(negedge clk);
            if (txn < 8) txcap[txn] = b;
            txn++;
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic spi_xfer(input logic [7:0] o, output logic [7:0] i);
      for (int b = 7; b >= 0; b--) begin
         spi_mosi = o[b];
         repeat (8) @(negedge clk);
         i[b] = spi_miso;
         spi_sck = 1'b1;
         repeat (8) @(negedge clk);
         spi_sck = 1'b0;
      end
   endtask

   task automatic cs_on;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic cs_off;
      repeat (8) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic uart_send(input logic [7:0] v);
      uart_rx = 1'b0;
      repeat (DIV) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         uart_rx = v[k];
         repeat (DIV) @(negedge clk);
      end
      uart_rx = 1'b1;
      repeat (DIV + 20) @(negedge clk);
   endtask

   // command, host byte, expected reply byte
   localparam int NV = 8;
   localparam logic [23:0] VEC [NV] = '{
      {8'h08, 8'h00, 8'h00},   // R8 first status
      {8'h08, 8'h00, 8'hAA},   // R8 second status
      {8'h08, 8'h00, 8'hAA},   // R8 third status
      {8'h01, 8'h02, 8'h00},   // R5 empty read
      {8'h08, 8'h00, 8'h00},   // R8 restart after other command
      {8'h5A, 8'h02, 8'hFF},   // R10 unknown
      {8'h08, 8'h00, 8'h00},   // R10 status restarts
      {8'h80, 8'h02, 8'hFF}    // R10 unknown
   };

   initial begin
      repeat (150_000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      chk("R1 reset miso", {7'd0, spi_miso}, 8'd1);
      chk("R3 reset mem_cs_n", {7'd0, mem_cs_n}, 8'd1);
      chk("R11 reset uart idle", {7'd0, uart_tx}, 8'd1);

      for (int v = 0; v < NV; v++) begin
         cs_on();
         spi_xfer(VEC[v][23:16], r);
         chk("R1 command phase", r, 8'hFF);
         spi_xfer(VEC[v][15:8], r);
         chk("R8/R10 table reply", r, VEC[v][7:0]);
         cs_off();
      end
      repeat (200) @(negedge clk);
      chk("R10 R6 nothing sent", 8'(txn), 8'd0);

      // receive path
      uart_send(8'h12);
      uart_send(8'h34);
      uart_send(8'hA5);
      cs_on();
      spi_xfer(8'h08, r);
      spi_xfer(8'h00, r);
      chk("R9 status with data", r, 8'hAA);
      cs_off();

      cs_on();
      spi_xfer(8'h01, r);
      spi_xfer(8'h02, r);
      chk("R4 count", r, 8'd3);
      spi_xfer(8'h02, r);
      chk("R4 byte0", r, 8'h12);
      spi_xfer(8'hFF, r);
      chk("R4 byte1", r, 8'h34);
      spi_xfer(8'h08, r);
      chk("R4 byte2", r, 8'hA5);
      spi_xfer(8'h55, r);
      chk("R4 pad", r, 8'h00);
      cs_off();

      cs_on();
      spi_xfer(8'h01, r);
      spi_xfer(8'h00, r);
      chk("R4 R5 drained", r, 8'd0);
      cs_off();
      repeat (200) @(negedge clk);
      chk("R6 host bytes ignored", 8'(txn), 8'd0);

      // transmit path
      cs_on();
      spi_xfer(8'h02, r);
      spi_xfer(8'h3C, r);
      spi_xfer(8'hC3, r);
      cs_off();
      repeat (40 * DIV) @(negedge clk);
      chk("R7 frame count", 8'(txn), 8'd2);
      chk("R7 R11 frame0", txcap[0], 8'h3C);
      chk("R7 R11 frame1", txcap[1], 8'hC3);

      // passthrough
      cs_on();
      spi_xfer(8'h00, r);
      repeat (4) @(negedge clk);
      chk("R3 mem selected", {7'd0, mem_cs_n}, 8'd0);
      mem_miso = 1'b0;
      #1 chk("R3 miso low", {7'd0, spi_miso}, 8'd0);
      mem_miso = 1'b1;
      #1 chk("R3 miso high", {7'd0, spi_miso}, 8'd1);
      spi_mosi = 1'b1;
      spi_sck = 1'b1;
      #1 chk("R3 sck mosi fwd", {6'd0, mem_sck, mem_mosi}, 8'd3);
      repeat (8) @(negedge clk);
      spi_sck = 1'b0;
      cs_off();
      chk("R3 mem released", {7'd0, mem_cs_n}, 8'd1);

      cs_on();
      spi_xfer(8'h08, r);
      chk("R2 command phase after pass", r, 8'hFF);
      spi_xfer(8'h00, r);
      chk("R2 decoded after pass", r, 8'h00);
      cs_off();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule